// File: doc/BRIEF.md
# Sleep Mode Clock Controller

This block sits beside the instruction decoder and turns two sleep opcodes into clock and oscillator enables. The idle opcode stops the CPU clock and leaves the oscillator and the peripheral clock running, so timers and interrupt inputs keep working. An enabled interrupt wakes the block, and execution continues at the next instruction. The deep-sleep opcode stops the CPU clock, the peripheral clock and the oscillator. Only a reset event (watchdog, stop-recovery or external) brings the block back, and that event restarts the program at a fixed vector.

A sleep opcode is honoured only when a valid no-operation opcode was decoded in the cycle just before it. That cycle flushes the pipeline. A sleep opcode without that lead-in is dropped, and a sticky sequence-error flag records it. The flag clears only on power-on reset.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: After power-on reset (rst_n_i low) the block is in run mode: mode_o = 00, CPU clock, oscillator and peripheral clock enables all 1, restart_o = 0, seq_err_o = 0.
- R2: In run mode, a valid opcode 7Fh in the cycle right after a valid opcode FFh enters idle. From the next cycle mode_o = 01, cpu_clk_en_o = 0, osc_en_o = 1, per_clk_en_o = 1.
- R3: In run mode, a valid opcode 6Fh in the cycle right after a valid opcode FFh enters deep sleep. From the next cycle mode_o = 10 and all three enables are 0.
- R4: A valid 7Fh or 6Fh that does not directly follow a valid FFh is ignored, so the mode stays run. seq_err_o is set from the next cycle and stays 1 until power-on reset.
- R5: In idle, any bit set in both irq_req_i and irq_en_i returns the block to run mode on the next cycle, with restart_o left at 0.
- R6: In idle, interrupt requests whose enable bit is 0 have no effect, and the CPU clock stays gated.
- R7: In deep sleep, interrupt requests have no effect, even when enabled.
- R8: A reset event (wdt_rst_i, smr_evt_i or ext_rst_i high) in any mode puts the block in run mode on the next cycle. In that same cycle restart_o pulses high for one cycle. restart_vec_o always reads 000Ch.
- R9: mode_o takes only the values 00 (run), 01 (idle) and 10 (deep sleep).
- R10: A reset event takes priority over a sleep opcode or a wake interrupt in the same cycle.
- R11: An opcode with op_valid_i low is ignored. It does not count as the lead-in FFh and does not trigger a sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_n_i | input | 1 | Asynchronous power-on reset, active low |
| op_valid_i | input | 1 | Decoded opcode valid |
| op_code_i | input | 8 | Decoded opcode |
| irq_req_i | input | NIRQ | Interrupt requests |
| irq_en_i | input | NIRQ | Interrupt enables |
| wdt_rst_i | input | 1 | Watchdog timeout reset event |
| smr_evt_i | input | 1 | Stop-recovery reset event |
| ext_rst_i | input | 1 | External reset event |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| per_clk_en_o | output | 1 | Peripheral/timer clock enable |
| restart_o | output | 1 | One-cycle restart pulse after a reset event |
| restart_vec_o | output | VEC_W | Restart address |
| mode_o | output | 2 | Current mode |
| seq_err_o | output | 1 | Sticky sleep-sequence error |

## Verification
The bench targets four cases. In the first, a no-operation opcode and a sleep opcode are separated by an invalid bubble cycle; a design that keyed on the raw opcode bus would enter sleep wrongly. In the second, a masked interrupt arrives during idle, and an enabled one arrives during deep sleep; a design that treated any request as a wake would release the clock early. In the third, a reset event coincides with a sleep entry or with an idle wake; a design with the wrong priority would sleep through a reset, or would skip the restart pulse. The last case checks that the error flag survives reset events, so a design that cleared it on every reset would lose the record.

// File: rtl/sleep_clk_ctrl.sv
`timescale 1ns/1ps
module sleep_clk_ctrl #(
  parameter int NIRQ = 5,
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] RESTART_VEC = 'h000C,
  parameter logic [7:0] OP_NOP = 8'hFF,
  parameter logic [7:0] OP_IDLE = 8'h7F,
  parameter logic [7:0] OP_DEEP = 8'h6F
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             op_valid_i,
  input  logic [7:0]       op_code_i,
  input  logic [NIRQ-1:0]  irq_req_i,
  input  logic [NIRQ-1:0]  irq_en_i,
  input  logic             wdt_rst_i,
  input  logic             smr_evt_i,
  input  logic             ext_rst_i,
  output logic             cpu_clk_en_o,
  output logic             osc_en_o,
  output logic             per_clk_en_o,
  output logic             restart_o,
  output logic [VEC_W-1:0] restart_vec_o,
  output logic [1:0]       mode_o,
  output logic             seq_err_o
);
  localparam logic [1:0] M_RUN = 2'b00, M_IDLE = 2'b01, M_DEEP = 2'b10;

  logic [1:0] mode_q;
  logic prev_nop_q, err_q, restart_q;

  wire rst_evt = wdt_rst_i | smr_evt_i | ext_rst_i;
  wire op_nop  = op_valid_i && (op_code_i == OP_NOP);
  wire op_idle = op_valid_i && (op_code_i == OP_IDLE);
  wire op_deep = op_valid_i && (op_code_i == OP_DEEP);
  wire wake    = |(irq_req_i & irq_en_i);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mode_q     <= M_RUN;
      prev_nop_q <= 1'b0;
      err_q      <= 1'b0;
      restart_q  <= 1'b0;
    end else begin
      restart_q <= rst_evt;
      if (rst_evt) begin
        mode_q     <= M_RUN;
        prev_nop_q <= 1'b0;
      end else begin
        prev_nop_q <= (mode_q == M_RUN) && op_nop;
        case (mode_q)
          M_RUN:
            if (op_idle || op_deep) begin
              if (prev_nop_q) mode_q <= op_idle ? M_IDLE : M_DEEP;
              else            err_q  <= 1'b1;
            end
          M_IDLE: if (wake) mode_q <= M_RUN;
          M_DEEP: ;
          default: mode_q <= M_RUN;
        endcase
      end
    end
  end

  assign cpu_clk_en_o  = (mode_q == M_RUN);
  assign osc_en_o      = (mode_q != M_DEEP);
  assign per_clk_en_o  = (mode_q != M_DEEP);
  assign restart_o     = restart_q;
  assign restart_vec_o = RESTART_VEC;
  assign mode_o        = mode_q;
  assign seq_err_o     = err_q;
endmodule

// File: rtl/sleep_clk_ctrl_chk.sv
`timescale 1ns/1ps
module sleep_clk_ctrl_chk #(
  parameter int NIRQ = 5
) (
  input logic            clk_i,
  input logic            rst_n_i,
  input logic [NIRQ-1:0] irq_req_i,
  input logic [NIRQ-1:0] irq_en_i,
  input logic            wdt_rst_i,
  input logic            smr_evt_i,
  input logic            ext_rst_i,
  input logic            cpu_clk_en_o,
  input logic            osc_en_o,
  input logic            per_clk_en_o,
  input logic            restart_o,
  input logic [1:0]      mode_o,
  input logic            seq_err_o
);
  wire rst_any = wdt_rst_i | smr_evt_i | ext_rst_i;
  wire wake = |(irq_req_i & irq_en_i);

  assert_mode_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    mode_o != 2'b11);
  assert_idle_enables_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    mode_o == 2'b01 |-> !cpu_clk_en_o && osc_en_o && per_clk_en_o);
  assert_deep_enables_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    mode_o == 2'b10 |-> !cpu_clk_en_o && !osc_en_o && !per_clk_en_o);
  assert_err_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    seq_err_o |=> seq_err_o);
  assert_idle_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_o == 2'b01 && wake && !rst_any) |=> (mode_o == 2'b00 && !restart_o));
  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_o == 2'b01 && !wake && !rst_any) |=> mode_o == 2'b01);
  assert_deep_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_o == 2'b10 && !rst_any) |=> mode_o == 2'b10);
  assert_reset_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rst_any |=> (restart_o && mode_o == 2'b00));
endmodule

bind sleep_clk_ctrl sleep_clk_ctrl_chk #(.NIRQ(NIRQ)) chk_i (
  .clk_i(clk_i), .rst_n_i(rst_n_i), .irq_req_i(irq_req_i), .irq_en_i(irq_en_i),
  .wdt_rst_i(wdt_rst_i), .smr_evt_i(smr_evt_i), .ext_rst_i(ext_rst_i),
  .cpu_clk_en_o(cpu_clk_en_o), .osc_en_o(osc_en_o), .per_clk_en_o(per_clk_en_o),
  .restart_o(restart_o), .mode_o(mode_o), .seq_err_o(seq_err_o));

// File: tb/sleep_clk_ctrl_tb_top.sv
`timescale 1ns/1ps
module sleep_clk_ctrl_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic op_valid = 0;
  logic [7:0] op_code = 0;
  logic [4:0] irq_req = 0, irq_en = 0;
  logic wdt = 0, smr = 0, ext = 0;
  logic cpu_en, osc_en, per_en, restart, err;
  logic [15:0] vec;
  logic [1:0] mode;

  int total = 0, bad = 0;
  int m_mode = 0;
  bit m_prev = 0, m_err = 0, m_rst = 0;

  always #2.5 clk = ~clk;

  sleep_clk_ctrl dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .op_valid_i(op_valid), .op_code_i(op_code),
    .irq_req_i(irq_req), .irq_en_i(irq_en), .wdt_rst_i(wdt), .smr_evt_i(smr),
    .ext_rst_i(ext), .cpu_clk_en_o(cpu_en), .osc_en_o(osc_en), .per_clk_en_o(per_en),
    .restart_o(restart), .restart_vec_o(vec), .mode_o(mode), .seq_err_o(err));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " mode"}, mode, m_mode);
    chk({tag, " cpu_en"}, cpu_en, m_mode == 0);
    chk({tag, " osc_en"}, osc_en, m_mode != 2);
    chk({tag, " per_en"}, per_en, m_mode != 2);
    chk({tag, " restart"}, restart, m_rst);
    chk({tag, " err"}, err, m_err);
    chk({tag, " R8 vec"}, vec, 16'h000C);
  endtask

  task automatic cyc(string tag, bit v, logic [7:0] op, logic [4:0] rq = 0,
                     logic [4:0] en = 0, bit w = 0, bit s = 0, bit e = 0);
    bit any;
    op_valid = v; op_code = op; irq_req = rq; irq_en = en; wdt = w; smr = s; ext = e;
    @(posedge clk);
    any = w | s | e;
    m_rst = any;
    if (any) begin
      m_mode = 0; m_prev = 0;
    end else if (m_mode == 0) begin
      if (v && (op == 8'h7F || op == 8'h6F)) begin
        if (m_prev) m_mode = (op == 8'h7F) ? 1 : 2;
        else m_err = 1;
      end
      m_prev = v && op == 8'hFF;
    end else begin
      if (m_mode == 1 && (rq & en) != 0) m_mode = 0;
      m_prev = 0;
    end
    #1;
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    rst_n = 1;
    cyc("R1 idle run", 0, 8'h00);
    cyc("R1 nop", 1, 8'hFF);
    // enter idle
    cyc("R2 nop", 1, 8'hFF);
    cyc("R2 halt", 1, 8'h7F);
    cyc("R6 masked", 0, 0, 5'b11111, 5'b00000);
    cyc("R6 masked2", 0, 0, 5'b00100, 5'b11011);
    cyc("R2 opcode in idle", 1, 8'h6F);
    cyc("R5 wake", 0, 0, 5'b00100, 5'b00100);
    cyc("R5 after", 0, 0);
    // missing lead-in
    cyc("R4 plain op", 1, 8'h12);
    cyc("R4 stop no nop", 1, 8'h6F);
    cyc("R4 sticky", 0, 0);
    // bubble between nop and sleep
    cyc("R11 nop", 1, 8'hFF);
    cyc("R11 bubble", 0, 8'h00);
    cyc("R11 halt", 1, 8'h7F);
    cyc("R11 invalid nop", 0, 8'hFF);
    cyc("R11 halt2", 1, 8'h7F);
    cyc("R11 invalid halt", 1, 8'hFF);
    cyc("R11 invalid halt2", 0, 8'h7F);
    // deep sleep
    cyc("R3 nop", 1, 8'hFF);
    cyc("R3 stop", 1, 8'h6F);
    cyc("R7 irq", 0, 0, 5'b11111, 5'b11111);
    cyc("R7 irq2", 1, 8'h7F, 5'b00001, 5'b00001);
    cyc("R8 smr", 0, 0, 0, 0, 0, 1, 0);
    cyc("R8 after", 0, 0);
    // watchdog out of idle
    cyc("R2 nop b", 1, 8'hFF);
    cyc("R2 halt b", 1, 8'h7F);
    cyc("R8 wdt", 0, 0, 0, 0, 1, 0, 0);
    cyc("R8 ext run", 0, 0, 0, 0, 0, 0, 1);
    // deep sleep left by external reset
    cyc("R3 nop b", 1, 8'hFF);
    cyc("R3 stop b", 1, 8'h6F);
    cyc("R8 ext", 0, 0, 0, 0, 0, 0, 1);
    // priority
    cyc("R10 nop", 1, 8'hFF);
    cyc("R10 halt+ext", 1, 8'h7F, 0, 0, 0, 0, 1);
    cyc("R10 halt late", 1, 8'h7F);
    cyc("R10 nop c", 1, 8'hFF);
    cyc("R10 halt c", 1, 8'h7F);
    cyc("R10 wake+wdt", 0, 0, 5'b10000, 5'b10000, 1, 0, 0);
    cyc("R10 after", 0, 0);
    // mode encoding held across
    cyc("R9 nop", 1, 8'hFF);
    cyc("R9 stop", 1, 8'h6F);
    cyc("R9 stay", 0, 0);
    cyc("R9 wdt", 0, 0, 0, 0, 1, 0, 0);
    cyc("R9 end", 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule